// File: doc/BRIEF.md
# Rounding Dual Multiply-Accumulate-High Unit

This block is a multi-cycle datapath that reduces two 128-bit operand vectors, each holding four 32-bit elements, into a 64-bit accumulator. A single multiplier is shared by all four lanes. On each beat it forms the full 64-bit product of one element from each vector, rounds that product, scales it down by 256 and adds it to the running 64-bit sum. The sum is brought back to 64 bits after every beat, so no wider running total is ever kept.

The caller applies the two vectors, a 16-bit lane predicate, a starting accumulator and three mode bits, then pulses `start_i`. The unit captures all of these inputs, stays busy for four beats (lane 0 first), and then raises `done_o` for one cycle with the final value on `result_o`.

Mode bits:
- Signed or unsigned element interpretation.
- An exchanged pairing, in which each lane takes its first-vector element from the neighbouring lane of the same pair.
- Negation of odd-lane products.

Exchange and negation are only honoured in signed mode.

Top module: `rmh_unit`

## Requirements
- R1: Each vector holds four 32-bit elements, with element e at bits [32e+31:32e]. One lane is processed per beat, in the order lane 0, 1, 2, 3, so `busy_o` stays high for exactly four cycles after a start is accepted.
- R2: Each lane product is the full 64-bit result of a 32x32 multiply; it is never truncated to 32 bits.
- R3: Lane e is enabled by predicate bit 4e. The other predicate bits have no effect. A disabled lane leaves the accumulator unchanged.
- R4: An enabled lane adds floor(P / 256) + bit 7 of P to the accumulator, where P is the (possibly negated) product. The addition wraps modulo 2^64 after every beat.
- R5: With exchange set, an even lane e multiplies first-vector element e+1 by second-vector element e. An odd lane e multiplies first-vector element e-1 by second-vector element e. With exchange clear, both vectors use element e.
- R6: With subtract set, products of lanes 1 and 3 are negated before rounding. Products of lanes 0 and 2 are always added.
- R7: Signed mode treats elements and the product as two's complement and uses an arithmetic shift. Unsigned mode zero-extends, shifts logically, and ignores the exchange and subtract bits.
- R8: A start accepted on one rising edge produces `done_o` high for exactly one cycle, four edges later, with `busy_o` low from then on.
- R9: `start_i` is ignored while `busy_o` is high. Inputs applied during that time do not change the running operation or its result.
- R10: Synchronous active-high reset clears `busy_o`, `done_o`, the lane counter and `result_o`.
- R11: `result_o` holds its value from one completion until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation when not busy |
| vec_a_i | input | 128 | First operand vector, four 32-bit elements |
| vec_b_i | input | 128 | Second operand vector, four 32-bit elements |
| pred_i | input | 16 | Lane predicate, bit 4e enables lane e |
| acc_i | input | 64 | Starting accumulator value |
| signed_i | input | 1 | 1 = two's complement, 0 = unsigned |
| xchg_i | input | 1 | Exchanged pairing (signed only) |
| sub_i | input | 1 | Negate odd-lane products (signed only) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Final accumulator, held until the next completion |

## Verification
The assertions assume that `start_i` is driven to a known level on every clock edge outside reset. They also assume that the operands and mode bits only need to be valid on the edge where a start is accepted, because the unit captures them there.

The stimulus raises start only from an idle state, except in the cases that deliberately hold it high while busy. In those cases it drives unrelated operands throughout the busy window, so the capture assumption is tested rather than merely relied on.

Random operations draw the predicate as a full 16-bit value, so predicate bits that are not lane enables are also exercised.

// File: rtl/rmh_pkg.sv
package rmh_pkg;
  localparam int EW        = 32;
  localparam int AW        = 2 * EW;
  localparam int RND_SHIFT = 8;

  // Full-width product, optional negation, then rounding right shift.
  function automatic logic [AW-1:0] rmh_scaled(input logic [EW-1:0] a,
                                               input logic [EW-1:0] b,
                                               input logic          sgn,
                                               input logic          neg);
    logic [AW-1:0] p;
    logic [AW-1:0] sh;
    if (sgn) p = $signed({{EW{a[EW-1]}}, a}) * $signed({{EW{b[EW-1]}}, b});
    else     p = {{EW{1'b0}}, a} * {{EW{1'b0}}, b};
    if (neg) p = -p;
    if (sgn) sh = $signed(p) >>> RND_SHIFT;
    else     sh = p >> RND_SHIFT;
    return sh + {{(AW-1){1'b0}}, p[RND_SHIFT-1]};
  endfunction
endpackage

// File: rtl/rmh_operand_mux.sv
module rmh_operand_mux #(
  parameter int LANES = 4,
  parameter int EW    = 32,
  localparam int VW   = LANES * EW,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [VW-1:0] vec_a,
  input  logic [VW-1:0] vec_b,
  input  logic [LW-1:0] lane,
  input  logic          xchg,
  output logic [EW-1:0] op_a,
  output logic [EW-1:0] op_b
);
  logic [LW-1:0] a_idx;

  // Exchanged pairing takes the partner within the even/odd pair.
  assign a_idx = xchg ? (lane ^ LW'(1)) : lane;
  assign op_a  = vec_a[a_idx*EW +: EW];
  assign op_b  = vec_b[lane*EW +: EW];
endmodule

// File: rtl/rmh_round_term.sv
module rmh_round_term
  import rmh_pkg::*;
(
  input  logic [EW-1:0] op_a,
  input  logic [EW-1:0] op_b,
  input  logic          sgn,
  input  logic          neg,
  output logic [AW-1:0] term
);
  assign term = rmh_scaled(op_a, op_b, sgn, neg);
endmodule

// File: rtl/rmh_unit.sv
module rmh_unit
  import rmh_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int PRED_GRP = 4,
  localparam int VW      = LANES * EW,
  localparam int PW      = LANES * PRED_GRP,
  localparam int LW      = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [VW-1:0] vec_a_i,
  input  logic [VW-1:0] vec_b_i,
  input  logic [PW-1:0] pred_i,
  input  logic [AW-1:0] acc_i,
  input  logic          signed_i,
  input  logic          xchg_i,
  input  logic          sub_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] result_o
);
  logic          busy_q, done_q;
  logic [LW-1:0] lane_q;
  logic [AW-1:0] acc_q, res_q;
  logic [VW-1:0] va_q, vb_q;
  logic [PW-1:0] pred_q;
  logic          sgn_q, xchg_q, sub_q;

  // Named internal events
  logic          accept, last_lane, lane_en, neg;
  logic [EW-1:0] op_a, op_b;
  logic [AW-1:0] term, acc_next;

  assign accept    = start_i & ~busy_q;
  assign last_lane = (lane_q == LW'(LANES - 1));
  assign lane_en   = pred_q[0];
  assign neg       = sub_q & lane_q[0];
  assign acc_next  = acc_q + (lane_en ? term : '0);

  rmh_operand_mux #(.LANES(LANES), .EW(EW)) u_mux (
    .vec_a (va_q),
    .vec_b (vb_q),
    .lane  (lane_q),
    .xchg  (xchg_q),
    .op_a  (op_a),
    .op_b  (op_b)
  );

  rmh_round_term u_term (
    .op_a (op_a),
    .op_b (op_b),
    .sgn  (sgn_q),
    .neg  (neg),
    .term (term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      lane_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      pred_q <= '0;
      sgn_q  <= 1'b0;
      xchg_q <= 1'b0;
      sub_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        lane_q <= '0;
        acc_q  <= acc_i;
        va_q   <= vec_a_i;
        vb_q   <= vec_b_i;
        pred_q <= pred_i;
        sgn_q  <= signed_i;
        xchg_q <= xchg_i & signed_i;   // unsigned: straight pairing only
        sub_q  <= sub_i & signed_i;    // unsigned: add only
      end else if (busy_q) begin
        acc_q  <= acc_next;
        pred_q <= pred_q >> PRED_GRP;
        lane_q <= lane_q + LW'(1);
        if (last_lane) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= acc_next;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  // Assertions
  AST_LANE_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_lane) |=> (busy_q && lane_q == $past(lane_q) + LW'(1))); // R1
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !lane_en) |=> (acc_q == $past(acc_q))); // R3
  AST_UNSIGNED_RANGE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !sgn_q) |-> (term[AW-1:AW-RND_SHIFT] == '0)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (busy_q && last_lane) |=> (done_q && !busy_q)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8
  AST_BUSY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(va_q) && $stable(vb_q))); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && last_lane) |=> $stable(res_q)); // R11
endmodule

// File: tb/rmh_unit_tb.sv
module rmh_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [127:0] vec_a_i = '0, vec_b_i = '0;
  logic [15:0]  pred_i = '0;
  logic [63:0]  acc_i = '0;
  logic         signed_i = 1'b0, xchg_i = 1'b0, sub_i = 1'b0;
  logic         busy_o, done_o;
  logic [63:0]  result_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;   // 125 MHz

  rmh_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .vec_a_i(vec_a_i), .vec_b_i(vec_b_i),
    .pred_i(pred_i), .acc_i(acc_i), .signed_i(signed_i), .xchg_i(xchg_i), .sub_i(sub_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Reference: round-half-up as floor((P + 128) / 256), per lane, wrapping sum.
  function automatic logic [63:0] model(input logic [127:0] a, input logic [127:0] b,
                                        input logic [15:0] p, input logic [63:0] acc,
                                        input logic s, input logic x, input logic sb);
    logic [63:0] r;
    r = acc;
    if (!s) begin x = 1'b0; sb = 1'b0; end
    for (int ln = 0; ln < 4; ln++) begin
      if (p[4*ln]) begin
        int ia;
        logic [31:0] ea, eb;
        ia = x ? ((ln % 2 == 0) ? ln + 1 : ln - 1) : ln;
        ea = a[32*ia +: 32];
        eb = b[32*ln +: 32];
        if (s) begin
          longint pr;
          pr = longint'($signed(ea)) * longint'($signed(eb));
          if (sb && (ln % 2 == 1)) pr = 0 - pr;
          r = r + 64'((pr + 128) >>> 8);
        end else begin
          logic [64:0] up;
          up = {33'b0, ea} * {33'b0, eb};
          up = up + 65'd128;
          r = r + 64'(up >> 8);
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [15:0] p,
                        input logic [63:0] acc, input logic s, input logic x, input logic sb,
                        input bit poke, input string tag, input logic [63:0] exp);
    @(negedge clk);
    vec_a_i = a; vec_b_i = b; pred_i = p; acc_i = acc;
    signed_i = s; xchg_i = x; sub_i = sb; start_i = 1'b1;
    @(negedge clk);
    if (poke) begin   // R9: keep start high with different operands while busy
      vec_a_i = {$urandom(), $urandom(), $urandom(), $urandom()};
      vec_b_i = ~a; pred_i = 16'hFFFF; acc_i = ~acc; signed_i = ~s;
    end else start_i = 1'b0;
    chk("R8 busy after start", 64'(busy_o), 64'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(poke ? "R9 still busy" : "R1 busy per lane", 64'({busy_o, done_o}), 64'b10);
    end
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 done pulse", 64'({busy_o, done_o}), 64'b01);
    chk(tag, result_o, exp);
    @(negedge clk);
    chk("R8 done one cycle", 64'(done_o), 64'd0);
    chk("R11 result held", result_o, exp);
  endtask

  initial begin
    logic [127:0] a, b;
    logic [15:0]  p;
    logic [63:0]  acc;
    void'($urandom(32'd581));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset state", {61'b0, busy_o, done_o, 1'b0}, 64'd0);
    chk("R10 reset result", result_o, 64'd0);

    // R4: P=384 -> 1 + bit7(1) = 2
    run_op({96'b0, 32'd1}, {96'b0, 32'd384}, 16'h0001, 64'd10, 1, 0, 0, 0, "R4 rounding", 64'd12);
    // R4: P=-128 -> -1 + 1 = 0
    run_op({96'b0, 32'hFFFF_FFFF}, {96'b0, 32'd128}, 16'h0001, 64'd5, 1, 0, 0, 0, "R4 neg rounding", 64'd5);
    // R4 wrap: acc all ones + 2
    run_op({96'b0, 32'd1}, {96'b0, 32'd384}, 16'h0001, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 0, "R4 wrap", 64'd1);
    // R2: 2^16 * 2^16 = 2^32 -> 2^24
    run_op({96'b0, 32'h1_0000}, {96'b0, 32'h1_0000}, 16'h0001, 64'd0, 1, 0, 0, 0, "R2 full product", 64'h100_0000);
    // R1: lane 3 only uses the top elements
    run_op({32'd512, 96'b0}, {32'd256, 96'b0}, 16'h1000, 64'd0, 1, 0, 0, 0, "R1 lane 3 position", 64'd512);
    // R3: non-enable bits only
    run_op({4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 16'hEEEE, 64'd77, 1, 0, 0, 0, "R3 ignored bits", 64'd77);
    run_op({4{32'h1234}}, {4{32'h5678}}, 16'h0000, 64'd99, 0, 0, 0, 0, "R3 all disabled", 64'd99);
    // R5: lane0 exchanged uses a[1]*b[0]
    run_op({64'b0, 32'd256, 32'd0}, {96'b0, 32'd256}, 16'h0001, 64'd0, 1, 1, 0, 0, "R5 exchange", 64'd256);
    run_op({64'b0, 32'd256, 32'd0}, {96'b0, 32'd256}, 16'h0001, 64'd0, 1, 0, 0, 0, "R5 straight", 64'd0);
    // R6: lane1 negated, lane0 added
    run_op({64'b0, 32'd256, 32'd256}, {64'b0, 32'd256, 32'd512}, 16'h0010, 64'd0, 1, 0, 1, 0,
           "R6 odd negated", 64'hFFFF_FFFF_FFFF_FF00);
    run_op({64'b0, 32'd256, 32'd256}, {64'b0, 32'd256, 32'd512}, 16'h0011, 64'd0, 1, 0, 1, 0,
           "R6 even added", 64'd256);
    // R7: unsigned max, exchange/subtract bits ignored
    run_op({4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, 16'h0001, 64'd0, 0, 1, 1, 0,
           "R7 unsigned max", 64'h00FF_FFFF_FE00_0000);
    // R9: start held while busy
    run_op({4{32'h0001_0203}}, {4{32'hFEDC_BA98}}, 16'h1111, 64'd3, 1, 1, 1, 1, "R9 start ignored",
           model({4{32'h0001_0203}}, {4{32'hFEDC_BA98}}, 16'h1111, 64'd3, 1, 1, 1));

    for (int t = 0; t < 200; t++) begin
      int md;
      logic s, x, sb;
      a = {$urandom(), $urandom(), $urandom(), $urandom()};
      b = {$urandom(), $urandom(), $urandom(), $urandom()};
      p = 16'($urandom());
      acc = {$urandom(), $urandom()};
      md = t % 6;
      case (md)
        0: {s, x, sb} = 3'b100;
        1: {s, x, sb} = 3'b110;
        2: {s, x, sb} = 3'b101;
        3: {s, x, sb} = 3'b111;
        4: {s, x, sb} = 3'b000;
        default: {s, x, sb} = {1'b0, 2'($urandom())};
      endcase
      run_op(a, b, p, acc, s, x, sb, (t % 17 == 0),
             (md >= 4) ? "R7 random unsigned" : "R5 R6 random signed",
             model(a, b, p, acc, s, x, sb));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule